// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block watches the command pins of a single-data-rate synchronous DRAM with four banks. On every rising clock edge where clock enable is high, it turns the chip-select, row-strobe, column-strobe and write-enable levels into one command. It checks that command against its record of which banks are open. It then reports the command, its bank, row and column fields, an auto-precharge flag and a protocol-error pulse, one cycle after the edge that sampled the pins.

It keeps an open or idle flag and the open row for each bank, so monitors, controllers or memory models can follow bank state without decoding the pins themselves. Address bit 10 means different things for different commands. With a precharge it selects all banks. With a read or write it asks for the bank to close after the access. A mode-register write stores the 12-bit address as an opaque op-code. When clock enable is low, all tracked state holds still. If every bank is idle at that point, a power-down status output is raised.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When chip select is high at an enabled edge, the block reports NOP (code 0) and bank state does not change. The same holds for any encoding not listed in R2 to R7. Command codes are: NOP 0, Activate 1, Precharge one bank 2, Precharge all 3, Read 4, Write 5, Mode write 6.
- R2: Activate is chip select low, row strobe low, column strobe high and write enable high. It marks the bank given by `ba` as active and stores `addr` as that bank's open row.
- R3: Precharge is chip select low, row strobe low, column strobe high and write enable low, with `addr[10]` low. It returns the bank given by `ba` to idle. A bank that is already idle raises no error.
- R4: Precharge with `addr[10]` high returns all four banks to idle, whatever `ba` is, and reports code 3.
- R5: With chip select low, row strobe high and column strobe low, write enable high gives Read and write enable low gives Write. `cmd_col` is `addr[7:0]` and `cmd_ap` is `addr[10]`.
- R6: A Read or Write to an active bank with `addr[10]` high leaves that bank active in the cycle that reports the command. The bank goes idle at the next enabled edge. An Activate to that bank at that same edge is accepted without error.
- R7: Mode write is all four strobes low. It copies `addr` into `mode_reg`.
- R8: A Read or Write to an idle bank, or an Activate to an active bank, raises `proto_err` for one cycle. Bank flags and open rows stay unchanged, and no auto-precharge is scheduled.
- R9: At an edge where `cke` is low, the command pins are ignored. Bank flags, open rows, `mode_reg` and any pending auto-precharge hold. `cmd_o` reports NOP and `proto_err` is low.
- R10: `pdown` goes high after an edge with `cke` low while all banks are idle. It clears after the next edge with `cke` high.
- R11: While reset is asserted, all banks are idle, the open rows and `mode_reg` are zero, `cmd_o` is NOP, and `proto_err` and `pdown` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes tracking |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column or op-code bits |
| cmd_o | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Bank sampled with the command |
| cmd_row | output | 12 | Address sampled with the command |
| cmd_col | output | 8 | Column field of the sampled address |
| cmd_ap | output | 1 | Auto-precharge request of a Read or Write |
| proto_err | output | 1 | One-cycle protocol-error pulse |
| bank_active | output | 4 | Per-bank active flag |
| open_row | output | 48 | Open row per bank, bank n at bits 12n+11:12n |
| mode_reg | output | 12 | Last mode-write op-code |
| pdown | output | 1 | Power-down condition status |

## Verification
The hardest case to reach is a pending auto-precharge that meets something else at the very edge where it takes effect. One such case is a clock-enable stall that must keep the bank open until a later enabled edge. Another is an Activate to the same bank that must see the bank as already idle. The stimulus builds both directly: an Activate, then a Read or Write with bit 10 set, then either a `cke`-low cycle or an immediate re-Activate. The reference model releases the pending close only at the next enabled edge. A closing sweep then runs every strobe encoding across all banks with changing addresses.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BA_W-1:0]               ba,
  input  logic [ROW_W-1:0]              addr,
  output logic [2:0]                    cmd_o,
  output logic [BA_W-1:0]               cmd_bank,
  output logic [ROW_W-1:0]              cmd_row,
  output logic [COL_W-1:0]              cmd_col,
  output logic                          cmd_ap,
  output logic                          proto_err,
  output logic [(1<<BA_W)-1:0]          bank_active,
  output logic [(1<<BA_W)*ROW_W-1:0]    open_row,
  output logic [ROW_W-1:0]              mode_reg,
  output logic                          pdown
);
  localparam int NB = 1 << BA_W;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_PALL = 3'd3,
                         C_RD = 3'd4, C_WR = 3'd5, C_MRS = 3'd6;

  wire sel    = ~cs_n;
  wire is_act = sel & ~ras_n &  cas_n &  we_n;
  wire is_pre = sel & ~ras_n &  cas_n & ~we_n;
  wire is_rd  = sel &  ras_n & ~cas_n &  we_n;
  wire is_wr  = sel &  ras_n & ~cas_n & ~we_n;
  wire is_mrs = sel & ~ras_n & ~cas_n & ~we_n;
  wire is_col = is_rd | is_wr;
  wire ap_bit = addr[AP_BIT];

  logic            ap_pend;
  logic [BA_W-1:0] ap_bank;
  logic [NB-1:0]   live, next_act;
  logic            err_n;
  logic [2:0]      code;

  always_comb begin
    live = bank_active;
    if (ap_pend) live[ap_bank] = 1'b0;
  end

  always_comb begin
    next_act = live;
    err_n    = 1'b0;
    if (is_act) begin
      if (live[ba]) err_n = 1'b1;
      else          next_act[ba] = 1'b1;
    end
    if (is_pre) begin
      if (ap_bit) next_act = '0;
      else        next_act[ba] = 1'b0;
    end
    if (is_col && !live[ba]) err_n = 1'b1;
  end

  always_comb begin
    code = C_NOP;
    if (is_act)      code = C_ACT;
    else if (is_pre) code = ap_bit ? C_PALL : C_PRE;
    else if (is_rd)  code = C_RD;
    else if (is_wr)  code = C_WR;
    else if (is_mrs) code = C_MRS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o       <= C_NOP;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_ap      <= 1'b0;
      proto_err   <= 1'b0;
      bank_active <= '0;
      open_row    <= '0;
      mode_reg    <= '0;
      pdown       <= 1'b0;
      ap_pend     <= 1'b0;
      ap_bank     <= '0;
    end else if (!cke) begin
      cmd_o     <= C_NOP;
      proto_err <= 1'b0;
      pdown     <= ~|bank_active;
    end else begin
      pdown       <= 1'b0;
      bank_active <= next_act;
      ap_pend     <= is_col & ap_bit & live[ba];
      ap_bank     <= ba;
      if (is_act && !live[ba]) open_row[ba*ROW_W +: ROW_W] <= addr;
      if (is_mrs) mode_reg <= addr;
      cmd_o     <= code;
      cmd_bank  <= ba;
      cmd_row   <= addr;
      cmd_col   <= addr[COL_W-1:0];
      cmd_ap    <= is_col & ap_bit;
      proto_err <= err_n;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cke,
  input logic                       cs_n,
  input logic                       ras_n,
  input logic                       cas_n,
  input logic                       we_n,
  input logic [BA_W-1:0]            ba,
  input logic [ROW_W-1:0]           addr,
  input logic [2:0]                 cmd_o,
  input logic [BA_W-1:0]            cmd_bank,
  input logic                       cmd_ap,
  input logic                       proto_err,
  input logic [(1<<BA_W)-1:0]       bank_active,
  input logic [(1<<BA_W)*ROW_W-1:0] open_row,
  input logic [ROW_W-1:0]           mode_reg,
  input logic                       pdown
);
  wire ap_due  = (cmd_o == 3'd4 || cmd_o == 3'd5) && cmd_ap && !proto_err;
  wire act_in  = !cs_n && !ras_n && cas_n && we_n;
  wire pall_in = !cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT];

  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n && !ap_due) |=> (cmd_o == 3'd0 && $stable(bank_active)));

  a_r2_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && act_in) |=> bank_active[$past(ba)]);

  a_r4_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && pall_in) |=> (bank_active == '0 && cmd_o == 3'd3));

  a_r6_auto_close: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && ap_due && !act_in) |=> !bank_active[$past(cmd_bank)]);

  a_r8_err_kind: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (cmd_o == 3'd1 || cmd_o == 3'd4 || cmd_o == 3'd5));

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (cmd_o == 3'd0 && !proto_err && $stable(bank_active)
              && $stable(open_row) && $stable(mode_reg)));

  a_r10_pdown_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |-> bank_active == '0);
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W), .AP_BIT(AP_BIT)
) u_chk (.*);

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;
  logic clk = 0, rst_n = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0]  ba = 0;
  logic [11:0] addr = 0;
  logic [2:0]  cmd_o;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_row, mode_reg;
  logic [7:0]  cmd_col;
  logic        cmd_ap, proto_err, pdown;
  logic [3:0]  bank_active;
  logic [47:0] open_row;

  sdram_cmd_tracker u_sdram_cmd_tracker (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [2:0] cmd; logic [1:0] bank; logic [11:0] row; logic [7:0] col;
    logic ap, err, pd; logic [3:0] act; logic [47:0] rows; logic [11:0] mode;
    string tag;
  } exp_t;
  exp_t q[$];

  int compared = 0, mismatched = 0;
  logic [2:0] m_cmd = 0; logic [1:0] m_bank = 0; logic [11:0] m_row = 0, m_mode = 0;
  logic [7:0] m_col = 0; logic m_ap = 0, m_err = 0, m_pd = 0, m_pend = 0;
  logic [1:0] m_pb = 0; logic [3:0] m_act = 0; logic [47:0] m_rows = 0;

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if ({cmd_o, cmd_bank, cmd_row, cmd_col, cmd_ap, proto_err, pdown, bank_active, open_row, mode_reg}
          !== {e.cmd, e.bank, e.row, e.col, e.ap, e.err, e.pd, e.act, e.rows, e.mode}) begin
        mismatched++;
        $display("FAIL %s: got cmd=%0d bank=%0d row=%h col=%h ap=%b err=%b pd=%b act=%b rows=%h mode=%h | exp cmd=%0d bank=%0d row=%h col=%h ap=%b err=%b pd=%b act=%b rows=%h mode=%h",
          e.tag, cmd_o, cmd_bank, cmd_row, cmd_col, cmd_ap, proto_err, pdown, bank_active, open_row, mode_reg,
          e.cmd, e.bank, e.row, e.col, e.ap, e.err, e.pd, e.act, e.rows, e.mode);
      end
    end
  end

  task automatic drive(input bit ck, c, r, ca, w, input logic [1:0] b, input logic [11:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    cke = ck; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    if (!ck) begin
      m_cmd = 0; m_err = 0; m_pd = (m_act == 0);
    end else begin
      m_pd = 0; m_err = 0; m_cmd = 0; m_ap = 0;
      if (m_pend) m_act[m_pb] = 0;
      m_pend = 0;
      if (!c) case ({r, ca, w})
        3'b011: begin m_cmd = 1;
                  if (m_act[b]) m_err = 1; else begin m_act[b] = 1; m_rows[b*12 +: 12] = a; end end
        3'b010: if (a[10]) begin m_cmd = 3; m_act = 0; end else begin m_cmd = 2; m_act[b] = 0; end
        3'b101, 3'b100: begin m_cmd = w ? 3'd4 : 3'd5; m_ap = a[10];
                  if (!m_act[b]) m_err = 1; else if (a[10]) begin m_pend = 1; m_pb = b; end end
        3'b000: begin m_cmd = 6; m_mode = a; end
        default: ;
      endcase
      m_bank = b; m_row = a; m_col = a[7:0];
    end
    e.cmd = m_cmd; e.bank = m_bank; e.row = m_row; e.col = m_col; e.ap = m_ap; e.err = m_err;
    e.pd = m_pd; e.act = m_act; e.rows = m_rows; e.mode = m_mode; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic act(input logic [1:0] b, input logic [11:0] row, input string t); drive(1,0,0,1,1,b,row,t); endtask
  task automatic pre(input logic [1:0] b, input bit all, input string t); drive(1,0,0,1,0,b,{1'b0,all,10'h0},t); endtask
  task automatic rd(input logic [1:0] b, input logic [7:0] col, input bit ap, input string t); drive(1,0,1,0,1,b,{1'b0,ap,2'b11,col},t); endtask
  task automatic wr(input logic [1:0] b, input logic [7:0] col, input bit ap, input string t); drive(1,0,1,0,0,b,{1'b0,ap,2'b00,col},t); endtask
  task automatic nop(input string t); drive(1,0,1,1,1,2'd0,12'h0,t); endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [11:0] lf;
    repeat (3) @(negedge clk);
    compared++;
    if ({cmd_o, proto_err, pdown, bank_active, open_row, mode_reg} !== '0) begin
      mismatched++;
      $display("FAIL R11 reset: got cmd=%0d err=%b pd=%b act=%b, exp all zero", cmd_o, proto_err, pdown, bank_active);
    end
    rst_n = 1;
    drive(1,1,0,1,1,2'd0,12'h555,"R1 deselect masks activate");
    drive(1,0,0,0,1,2'd1,12'h000,"R1 refresh encoding is NOP");
    act(2'd0, 12'h123, "R2 activate bank0");
    act(2'd3, 12'hABC, "R2 activate bank3");
    act(2'd0, 12'h777, "R8 activate on active bank");
    rd(2'd0, 8'h45, 0, "R5 read bank0");
    wr(2'd3, 8'hFF, 0, "R5 write bank3");
    rd(2'd1, 8'h12, 0, "R8 read idle bank");
    wr(2'd2, 8'h34, 1, "R8 write idle bank with ap");
    nop("R8 no close scheduled");
    pre(2'd3, 0, "R3 precharge bank3");
    pre(2'd3, 0, "R3 precharge idle bank no error");
    rd(2'd0, 8'h99, 1, "R6 read with auto-precharge");
    nop("R6 bank0 closes one cycle later");
    act(2'd1, 12'h0F0, "R6 setup bank1");
    wr(2'd1, 8'h10, 1, "R6 write with auto-precharge");
    act(2'd1, 12'h0F1, "R6 re-activate at close edge");
    drive(1,0,0,0,0,2'd2,12'h237,"R7 mode write");
    act(2'd2, 12'h222, "R4 setup bank2");
    pre(2'd1, 1, "R4 precharge all");
    act(2'd0, 12'h3C3, "R9 setup bank0");
    drive(0,0,0,1,0,2'd0,12'h400,"R9 stall ignores precharge all");
    drive(0,0,0,0,0,2'd0,12'hFFF,"R9 stall ignores mode write");
    nop("R9 resume");
    rd(2'd0, 8'h01, 1, "R9 read ap before stall");
    drive(0,1,1,1,1,2'd0,12'h0,"R9 stall holds pending close");
    nop("R9 pending close after stall");
    drive(0,1,1,1,1,2'd0,12'h0,"R10 power-down when idle");
    drive(0,1,1,1,1,2'd0,12'h0,"R10 power-down held");
    nop("R10 power-down exit");
    lf = 12'hACE;
    for (int i = 0; i < 64; i++) begin
      lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
      drive(1, i[4], i[3], i[2], i[1], 2'(i + (i >> 4)), lf, "R1 R5 sweep");
    end
    nop("R11 drain");
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule